// File: doc/BRIEF.md
# Low-Transition Scan Pattern Generator

This block produces one serial bit stream for the input of a scan chain in a built-in self-test setup. Consecutive bits of the stream rarely differ, which keeps the toggling inside the scan chain low while patterns are shifted in. A maximal-length LFSR advances once per shift. A small AND term watches two or three chosen LFSR stages, each taken in true or complemented form. Whenever that term is 1 on a shift, a toggle flip-flop flips. The flip-flop's value is the scan-in bit, so the same value repeats until the AND term fires again.

The block also frames the stream for test-per-scan use: after a parameterized number of shift steps it raises a capture indication for one enabled cycle, during which the generator holds. A saturating counter reports how often the scan-in bit has changed. It can be compared against the number of changes a plain LFSR bit makes. A load input restarts the generator from a supplied seed. An enable input pauses it.

Top module: `lowtoggle_scan_gen`

## Requirements
- R1: In a cycle with `rst` high the block sets `lfsr_state` to `SEED_INIT`, and sets `scan_in`, `toggle_count` and `scan_capture` to 0. All outputs are registered and change only on a rising clock edge.
- R2: On a shift step the LFSR moves to `{s[LFSR_W-2:0], ^(s & FB_MASK)}`, where `s` is the current state. With the mask of a primitive polynomial, the state first returns to its start after 2^LFSR_W-1 shift steps and is never zero.
- R3: `load` high, whatever `en` is, sets `lfsr_state` to `seed`, clears `scan_in` and `toggle_count`, drops `scan_capture`, and restarts the shift count of the frame.
- R4: A load with `seed` equal to zero sets `lfsr_state` to `SEED_INIT` instead, so the LFSR cannot lock up.
- R5: Tap j (j < AND_K) is the LFSR bit at index `TAP_SEL[8*j +: 8]`, XORed with `TAP_INV[j]`. The AND term is the AND of the AND_K taps, taken from the state before the step. On a shift step, `scan_in` inverts exactly when the AND term is 1. Otherwise `scan_in` keeps its value.
- R6: With `en` low and no load or reset, every output holds its value.
- R7: `toggle_count` increases by one on every cycle in which `scan_in` changes outside of a load. It stays at all ones once it gets there.
- R8: A shift step is an enabled cycle with `scan_capture` at 0. After CHAIN_LEN shift steps `scan_capture` goes to 1. During the next enabled cycle the LFSR and `scan_in` hold, and `scan_capture` returns to 0.
- R9: AND_K may only be 2 or 3. Any other value is reported when the design elaborates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the frame by one cycle when high |
| load | input | 1 | Restart the generator from `seed` |
| seed | input | LFSR_W | Seed value used on load |
| scan_in | output | 1 | Serial bit for the scan chain input |
| scan_capture | output | 1 | High during the capture slot of each frame |
| lfsr_state | output | LFSR_W | Current LFSR contents |
| toggle_count | output | CNT_W | Saturating count of changes on `scan_in` |

## Verification
The bench builds the block with an 8-bit LFSR using mask 0xB8, three taps on stages 1, 3 and 6 with stage 6 inverted, a five-step chain and a 6-bit counter. The short LFSR lets one full period of 255 shift steps run, so the bench can check that the state returns to its start. The narrow counter reaches saturation within about a thousand cycles. The run also sets the number of changes on the scan bit against the number of changes on LFSR bit 0 over the same window. Other phases of the run cover loads during pause, zero seeds, and gaps in the enable that fall in both the shift and the capture slots.

// File: rtl/lts_pkg.sv
package lts_pkg;
  localparam int unsigned MAX_TAPS  = 3;
  localparam int unsigned TAP_IDX_W = 8;

  typedef enum logic {
    PH_SHIFT   = 1'b0,
    PH_CAPTURE = 1'b1
  } frame_phase_t;

  function automatic bit tap_count_ok(input int unsigned k);
    return (k == 2) || (k == 3);
  endfunction
endpackage

// File: rtl/lts_lfsr.sv
module lts_lfsr #(
  parameter int unsigned LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] FB_MASK   = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED_INIT = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LFSR_W-1:0] seed,
  input  logic              advance,
  output logic [LFSR_W-1:0] state
);
  logic              fb_bit;
  logic [LFSR_W-1:0] load_val;

  assign fb_bit   = ^(state & FB_MASK);
  assign load_val = (seed == '0) ? SEED_INIT : seed;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEED_INIT;
    end else if (load) begin
      state <= load_val;
    end else if (advance) begin
      state <= {state[LFSR_W-2:0], fb_bit};
    end
  end
endmodule

// File: rtl/lts_tap_and.sv
module lts_tap_and #(
  parameter int unsigned LFSR_W = 16,
  parameter int unsigned AND_K  = 2,
  parameter logic [lts_pkg::MAX_TAPS*lts_pkg::TAP_IDX_W-1:0] TAP_SEL = {8'd9, 8'd4, 8'd0},
  parameter logic [lts_pkg::MAX_TAPS-1:0] TAP_INV = 3'b010
) (
  input  logic [LFSR_W-1:0] state,
  output logic              hit
);
  localparam int unsigned IW = lts_pkg::TAP_IDX_W;
  logic [AND_K-1:0] terms;

  for (genvar j = 0; j < AND_K; j++) begin : g_tap
    localparam int unsigned SEL = int'(TAP_SEL[j*IW +: IW]);
    assign terms[j] = state[SEL] ^ TAP_INV[j];
  end

  assign hit = &terms;
endmodule

// File: rtl/lts_toggle_cell.sv
module lts_toggle_cell (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic advance,
  input  logic hit,
  output logic bit_q,
  output logic flip
);
  assign flip = advance & hit;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      bit_q <= 1'b0;
    end else if (flip) begin
      bit_q <= ~bit_q;
    end
  end
endmodule

// File: rtl/lts_trans_ctr.sv
module lts_trans_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count <= '0;
    end else if (inc && (count != CNT_MAX)) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/lts_frame_seq.sv
module lts_frame_seq #(
  parameter int unsigned CHAIN_LEN = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic en,
  output logic shift_ok,
  output logic capture_q
);
  import lts_pkg::*;
  localparam int unsigned SC_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(CHAIN_LEN - 1);

  frame_phase_t    phase;
  logic [SC_W-1:0] shift_cnt;

  assign shift_ok  = (phase == PH_SHIFT);
  assign capture_q = (phase == PH_CAPTURE);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase     <= PH_SHIFT;
      shift_cnt <= '0;
    end else if (en) begin
      if (phase == PH_SHIFT) begin
        if (shift_cnt == SC_LAST) begin
          shift_cnt <= '0;
          phase     <= PH_CAPTURE;
        end else begin
          shift_cnt <= shift_cnt + 1'b1;
        end
      end else begin
        phase <= PH_SHIFT;
      end
    end
  end
endmodule

// File: rtl/lowtoggle_scan_gen.sv
module lowtoggle_scan_gen #(
  parameter int unsigned LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] FB_MASK   = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED_INIT = 16'hACE1,
  parameter int unsigned AND_K     = 2,
  parameter logic [lts_pkg::MAX_TAPS*lts_pkg::TAP_IDX_W-1:0] TAP_SEL = {8'd9, 8'd4, 8'd0},
  parameter logic [lts_pkg::MAX_TAPS-1:0] TAP_INV = 3'b010,
  parameter int unsigned CHAIN_LEN = 32,
  parameter int unsigned CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic [LFSR_W-1:0] seed,
  output logic              scan_in,
  output logic              scan_capture,
  output logic [LFSR_W-1:0] lfsr_state,
  output logic [CNT_W-1:0]  toggle_count
);
  logic shift_ok;
  logic advance;
  logic and_hit;
  logic flip;

  assign advance = en & ~load & shift_ok;

  lts_frame_seq #(.CHAIN_LEN(CHAIN_LEN)) u_frame (
    .clk(clk), .rst(rst), .restart(load), .en(en),
    .shift_ok(shift_ok), .capture_q(scan_capture)
  );

  lts_lfsr #(.LFSR_W(LFSR_W), .FB_MASK(FB_MASK), .SEED_INIT(SEED_INIT)) u_lfsr (
    .clk(clk), .rst(rst), .load(load), .seed(seed),
    .advance(advance), .state(lfsr_state)
  );

  lts_tap_and #(.LFSR_W(LFSR_W), .AND_K(AND_K), .TAP_SEL(TAP_SEL), .TAP_INV(TAP_INV)) u_and (
    .state(lfsr_state), .hit(and_hit)
  );

  lts_toggle_cell u_tff (
    .clk(clk), .rst(rst), .clear(load), .advance(advance),
    .hit(and_hit), .bit_q(scan_in), .flip(flip)
  );

  lts_trans_ctr #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(load), .inc(flip), .count(toggle_count)
  );
endmodule

// File: rtl/lts_checker.sv
module lts_checker #(
  parameter int unsigned LFSR_W = 16,
  parameter int unsigned AND_K  = 2,
  parameter logic [lts_pkg::MAX_TAPS*lts_pkg::TAP_IDX_W-1:0] TAP_SEL = {8'd9, 8'd4, 8'd0},
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              load,
  input logic              scan_in,
  input logic              scan_capture,
  input logic [LFSR_W-1:0] lfsr_state,
  input logic [CNT_W-1:0]  toggle_count
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  initial begin
    assert_tap_count_R9: assert (lts_pkg::tap_count_ok(AND_K))
      else $error("AND_K must be 2 or 3 (R9)");
    for (int j = 0; j < AND_K; j++) begin
      assert_tap_range_R5: assert (int'(TAP_SEL[j*lts_pkg::TAP_IDX_W +: lts_pkg::TAP_IDX_W]) < LFSR_W)
        else $error("tap index out of range (R5)");
    end
  end

  assert_never_zero_R2: assert property (@(posedge clk) disable iff (rst)
    lfsr_state != '0);

  assert_load_clears_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> (scan_in == 1'b0) && (toggle_count == '0) && !scan_capture);

  assert_pause_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(lfsr_state) && $stable(scan_in)
                       && $stable(toggle_count) && $stable(scan_capture));

  assert_count_tracks_R7: assert property (@(posedge clk) disable iff (rst)
    !load |=> ((scan_in != $past(scan_in)) == (toggle_count != $past(toggle_count)))
              || ($past(toggle_count) == CMAX));

  assert_capture_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (scan_capture && en && !load) |=> $stable(lfsr_state) && $stable(scan_in) && !scan_capture);
endmodule

bind lowtoggle_scan_gen lts_checker #(
  .LFSR_W(LFSR_W), .AND_K(AND_K), .TAP_SEL(TAP_SEL), .CNT_W(CNT_W)
) u_lts_chk (
  .clk(clk), .rst(rst), .en(en), .load(load), .scan_in(scan_in),
  .scan_capture(scan_capture), .lfsr_state(lfsr_state), .toggle_count(toggle_count)
);

// File: tb/lowtoggle_scan_gen_test.sv
`timescale 1ns/1ps
module lowtoggle_scan_gen_test;
  localparam int W     = 8;
  localparam logic [W-1:0] FB   = 8'hB8;
  localparam logic [W-1:0] SINIT = 8'h3C;
  localparam int K     = 3;
  localparam int CH    = 5;
  localparam int CW    = 6;
  localparam int TAPS [3] = '{1, 3, 6};
  localparam logic [2:0] INV = 3'b100;

  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b0, load = 1'b0;
  logic [W-1:0] seed = '0;
  logic scan_in, scan_capture;
  logic [W-1:0] lfsr_state;
  logic [CW-1:0] toggle_count;

  always #10 clk = ~clk;

  lowtoggle_scan_gen #(
    .LFSR_W(W), .FB_MASK(FB), .SEED_INIT(SINIT), .AND_K(K),
    .TAP_SEL({8'd6, 8'd3, 8'd1}), .TAP_INV(INV), .CHAIN_LEN(CH), .CNT_W(CW)
  ) uut (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed),
    .scan_in(scan_in), .scan_capture(scan_capture),
    .lfsr_state(lfsr_state), .toggle_count(toggle_count)
  );

  typedef struct {
    logic [W-1:0]  lf;
    logic          sc;
    logic          cap;
    logic [CW-1:0] cnt;
    string         tag;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_fail = 0;
  logic [W-1:0]  m_lf = SINIT;
  logic          m_sc = 1'b0, m_cap = 1'b0;
  logic [CW-1:0] m_cnt = '0;
  int            m_pos = 0;
  bit            last_shift;
  bit            tally_on = 0;
  int            tr_scan = 0, tr_bit = 0;
  logic          p_sc;
  logic [W-1:0]  p_lf;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic taps_hit(logic [W-1:0] s);
    logic h = 1'b1;
    for (int j = 0; j < K; j++) h &= s[TAPS[j]] ^ INV[j];
    return h;
  endfunction

  // driver: applies one cycle of inputs and pushes the expected outcome
  task automatic drive(logic r, logic e, logic l, logic [W-1:0] sd, string tag);
    @(negedge clk);
    rst = r; en = e; load = l; seed = sd;
    last_shift = 0;
    if (r) begin
      m_lf = SINIT; m_sc = 0; m_cnt = '0; m_cap = 0; m_pos = 0;
    end else if (l) begin
      m_lf = (sd == '0) ? SINIT : sd; m_sc = 0; m_cnt = '0; m_cap = 0; m_pos = 0;
    end else if (e) begin
      if (!m_cap) begin
        last_shift = 1;
        if (taps_hit(m_lf)) begin
          m_sc = ~m_sc;
          if (m_cnt != '1) m_cnt = m_cnt + 1'b1;
        end
        m_lf = {m_lf[W-2:0], ^(m_lf & FB)};
        if (m_pos == CH - 1) begin m_pos = 0; m_cap = 1; end
        else m_pos++;
      end else begin
        m_cap = 0;
      end
    end
    q.push_back('{m_lf, m_sc, m_cap, m_cnt, tag});
  endtask

  // monitor: compares each expected item against the outputs after the edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      chk(x.tag, "lfsr_state", 32'(lfsr_state), 32'(x.lf));
      chk(x.tag, "scan_in", 32'(scan_in), 32'(x.sc));
      chk(x.tag, "scan_capture", 32'(scan_capture), 32'(x.cap));
      chk(x.tag, "toggle_count", 32'(toggle_count), 32'(x.cnt));
      if (tally_on) begin
        if (scan_in != p_sc) tr_scan++;
        if (lfsr_state[0] != p_lf[0]) tr_bit++;
      end
      p_sc = scan_in; p_lf = lfsr_state;
    end
  end

  task automatic run_shifts(int n, string tag);
    int done = 0;
    while (done < n) begin
      drive(0, 1, 0, '0, tag);
      if (last_shift) done++;
    end
  endtask

  initial begin
    repeat (3) drive(1, 1, 0, 8'hFF, "R1");
    @(posedge clk); #3;
    chk("R1", "reset lfsr_state", 32'(lfsr_state), 32'(SINIT));
    chk("R1", "reset scan_in", 32'(scan_in), 0);
    // R5 R8: free running frames
    repeat (40) drive(0, 1, 0, '0, "R5_R8");
    // R6: pauses in shift and in capture slots
    for (int i = 0; i < 36; i++) drive(0, (i % 3) == 0, 0, '0, "R6");
    // R3: load during pause, then with enable
    drive(0, 0, 1, 8'h5A, "R3");
    @(posedge clk); #3;
    chk("R3", "loaded lfsr_state", 32'(lfsr_state), 32'h5A);
    repeat (17) drive(0, 1, 0, '0, "R3");
    drive(0, 1, 1, 8'hC3, "R3");
    repeat (9) drive(0, 1, 0, '0, "R3");
    // R4: zero seed
    drive(0, 1, 1, 8'h00, "R4");
    @(posedge clk); #3;
    chk("R4", "zero seed replaced", 32'(lfsr_state), 32'(SINIT));
    // R2: a full period returns to the seed
    drive(0, 0, 1, 8'h01, "R2");
    run_shifts(255, "R2");
    @(posedge clk); #3;
    chk("R2", "period 255 returns to seed", 32'(lfsr_state), 32'h01);
    // R7: fewer changes on scan_in than on a plain LFSR bit
    drive(0, 0, 1, 8'hA7, "R7");
    @(posedge clk); #3;
    tally_on = 1;
    repeat (400) drive(0, 1, 0, '0, "R7");
    @(posedge clk); #3;
    tally_on = 0;
    chk("R7", "scan changes below lfsr bit changes", 32'(tr_scan < tr_bit), 1);
    chk("R7", "counter matches scan changes", 32'(toggle_count), 32'(tr_scan > 63 ? 63 : tr_scan));
    // R7: saturation
    repeat (1200) drive(0, 1, 0, '0, "R7");
    @(posedge clk); #3;
    chk("R7", "saturated count", 32'(toggle_count), 63);
    drive(0, 1, 1, 8'h11, "R3");
    repeat (3) drive(0, 0, 0, '0, "R6");
    @(posedge clk); #3;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule